// File: doc/BRIEF.md
# Luma/chroma interleaving serializer

This block turns a stream of 20-bit parallel video words into a single serial bit stream. Each parallel word holds one 10-bit chroma sample in its low half and one 10-bit luma sample in its high half. The block sends the chroma sample first and then the luma sample, each least significant bit first. That gives 20 serial bits per parallel word. The serial clock is an input that runs at 20 times the parallel word rate, which is nominally 74.25 MHz or 74.25/1.001 MHz. A load strobe, sampled on the serial clock, marks the slot in which the next word is taken in.

The load strobe is meant to be high during the slot that carries the last bit of the current word. The new word then follows with no idle slot. For sources that carry only 8 significant bits per sample, a narrow mode reads the upper 8 bits of each field and widens them to 10 bits. An all-ones sync value becomes the full 10-bit all-ones code, and every other value gets two zero bits appended below it. A separate input switches the all-ones sync mapping off.

Top module: `yc_serializer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first load, `sdata` is 0.
- R2: A word is captured on the rising `sclk` edge at which `load` is high. Its first serial bit appears on `sdata` in the cycle after that edge.
- R3: The serial order is chroma `word_in[9:0]` bit 0 through bit 9, then luma `word_in[19:10]` bit 0 through bit 9, one bit per `sclk` cycle.
- R4: When `load` is high during the 20th bit of a word, bit 0 of the next word follows in the very next cycle, with no gap.
- R5: With `narrow_mode` = 0, both samples are sent unchanged, and `sync_map_off` has no effect.
- R6: With `narrow_mode` = 1, only bits [9:2] of each 10-bit field matter and bits [1:0] are ignored. A value that is not a sync value is sent as {bits[9:2], 2'b00}.
- R7: With `narrow_mode` = 1 and `sync_map_off` = 0, a field whose bits [9:2] are 8'hFF is sent as 10'h3FF.
- R8: With `narrow_mode` = 1, a field whose bits [9:2] are 8'h00 is sent as 10'h000, whatever the value of `sync_map_off`.
- R9: With `narrow_mode` = 1 and `sync_map_off` = 1, a field whose bits [9:2] are 8'hFF is sent as 10'h3FC.
- R10: `word_in`, `narrow_mode` and `sync_map_off` are used only in the cycle in which `load` is high. Changing them in other cycles does not alter the word being shifted out.
- R11: If no load occurs during the 20th bit, `sdata` is 0 from the next cycle until a new word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock, 20 times the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture strobe; high during the last bit slot of the current word |
| word_in | input | 20 | Parallel word: luma in [19:10], chroma in [9:0] |
| narrow_mode | input | 1 | 1 = 8 significant bits per sample, 0 = 10 bits |
| sync_map_off | input | 1 | 1 = do not widen all-ones sync values in narrow mode |
| sdata | output | 1 | Serial data out |

## Verification
The case that is hardest to reach from the ports is a load that arrives exactly on the 20th bit, while the inputs that should be ignored keep changing in every other slot. Only then does the check show that framing stays gap-free (R4) and that the mode inputs are taken only at capture (R10). The bench therefore runs a continuous stream of words with the strobe placed on bit 19 every time. It randomizes `word_in`, `narrow_mode` and `sync_map_off` in all 19 other slots. It opens with directed words that hit each sync mapping in both states of `sync_map_off`, then continues with words from a seeded random source. A final stretch with no load confirms that zeros follow the last word.

// File: rtl/yc_serializer.sv
module yc_serializer #(
  parameter int SAMPLE_W = 10,
  parameter int NARROW_W = 8
) (
  input  logic                  sclk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [2*SAMPLE_W-1:0] word_in,
  input  logic                  narrow_mode,
  input  logic                  sync_map_off,
  output logic                  sdata
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int PAD_W  = SAMPLE_W - NARROW_W;

  function automatic logic [SAMPLE_W-1:0] widen(input logic [SAMPLE_W-1:0] s,
                                                input logic nm, input logic off);
    logic [NARROW_W-1:0] top;
    top = s[SAMPLE_W-1 -: NARROW_W];
    if (!nm) return s;
    if (!off && (&top)) return {SAMPLE_W{1'b1}};
    return {top, {PAD_W{1'b0}}};
  endfunction

  logic [WORD_W-1:0] mapped;
  logic [WORD_W-1:0] shreg;

  for (genvar g = 0; g < 2; g++) begin : g_field
    assign mapped[g*SAMPLE_W +: SAMPLE_W] =
      widen(word_in[g*SAMPLE_W +: SAMPLE_W], narrow_mode, sync_map_off);
  end

  always_ff @(posedge sclk) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= mapped;
    else           shreg <= {1'b0, shreg[WORD_W-1:1]};
  end

  assign sdata = shreg[0];

  // R2 / R5: first bit after a capture comes straight from the chroma field
  p_wide_first_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    (load && !narrow_mode) |=> (sdata == $past(word_in[0])));

  // R3 / R10: without a load the stream advances by exactly one bit
  p_shift_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !load |=> (sdata == $past(shreg[1])));

  p_sync_ones_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    (load && narrow_mode && !sync_map_off && (&word_in[SAMPLE_W-1 -: NARROW_W]))
      |=> sdata);

  p_sync_zero_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    (load && narrow_mode && (word_in[SAMPLE_W-1 -: NARROW_W] == '0)) |=> !sdata);

  p_no_map_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    (load && narrow_mode && sync_map_off) |=> !sdata);

  p_reset_clear_r1: assert property (@(posedge sclk)
    !rst_n |=> !sdata);
endmodule

// File: tb/sim_yc_serializer.sv
module sim_yc_serializer;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        sync_map_off = 1'b0;
  logic [19:0] word_in = '0;
  logic        sdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 sclk = ~sclk;

  yc_serializer u0 (
    .sclk(sclk), .rst_n(rst_n), .load(load), .word_in(word_in),
    .narrow_mode(narrow_mode), .sync_map_off(sync_map_off), .sdata(sdata)
  );

  function automatic logic [9:0] ref_sample(logic [9:0] s, logic nm, logic off);
    if (!nm) return s;
    if (!off && s[9:2] == 8'hFF) return 10'h3FF;
    return {s[9:2], 2'b00};
  endfunction

  function automatic logic [19:0] ref_word(logic [19:0] w, logic nm, logic off);
    return {ref_sample(w[19:10], nm, off), ref_sample(w[9:0], nm, off)};
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sdata=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pick(int i, output logic [19:0] w, output logic nm,
                      output logic off, output string tag);
    case (i)
      0: begin w = {10'h2A5, 10'h15A}; nm = 0; off = 1; tag = "R5"; end
      1: begin w = {10'h3FE, 10'h3FD}; nm = 1; off = 0; tag = "R7 R6"; end
      2: begin w = {10'h3FF, 10'h3FE}; nm = 1; off = 1; tag = "R9"; end
      3: begin w = {10'h003, 10'h002}; nm = 1; off = 0; tag = "R8"; end
      4: begin w = {10'h001, 10'h000}; nm = 1; off = 1; tag = "R8 R9"; end
      5: begin w = {10'h2B7, 10'h1C9}; nm = 1; off = 0; tag = "R6"; end
      6: begin w = 20'hFFFFF;          nm = 0; off = 0; tag = "R5"; end
      7: begin w = {10'h3FF, 10'h000}; nm = 0; off = 1; tag = "R5"; end
      default: begin
        w = 20'($urandom); nm = 1'($urandom); off = 1'($urandom); tag = "R3";
      end
    endcase
  endtask

  task automatic stream(int first, int n);
    logic [19:0] w, exp, nxt;
    logic nm, off;
    string tag, ntag;
    @(negedge sclk);
    pick(first, w, nm, off, tag);
    word_in = w; narrow_mode = nm; sync_map_off = off; load = 1'b1;
    exp = ref_word(w, nm, off);
    nxt = exp; ntag = tag;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 20; k++) begin
        @(negedge sclk);
        check(sdata, exp[k], {tag, (k == 0) ? " R2 R4" : " R3 R10"});
        if (k == 19 && i < n - 1) begin
          pick(first + i + 1, w, nm, off, ntag);
          word_in = w; narrow_mode = nm; sync_map_off = off; load = 1'b1;
          nxt = ref_word(w, nm, off);
        end else begin
          load = 1'b0;
          word_in = 20'($urandom); narrow_mode = 1'($urandom);
          sync_map_off = 1'($urandom);
        end
      end
      exp = nxt; tag = ntag;
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    repeat (3) begin @(negedge sclk); check(sdata, 1'b0, "R1 reset"); end
    rst_n = 1'b1;
    repeat (4) begin @(negedge sclk); check(sdata, 1'b0, "R1 idle"); end
    stream(0, 8);
    repeat (25) begin @(negedge sclk); check(sdata, 1'b0, "R11"); end
    stream(8, 200);
    repeat (25) begin @(negedge sclk); check(sdata, 1'b0, "R11"); end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge sclk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: run not finished, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule